// File: doc/BRIEF.md
# Mixed-Mode Interrupt Controller With Reset Switch

This block collects 32 interrupt sources behind a small 32-bit register bus and drives one combined interrupt line to the processor. Software finds pending sources in a cause register and enables sources in a mask register of the same layout. Most sources follow their input level. If a source drops, its cause bit clears with no software action.

One position belongs to the reset push-button. A press latches a sticky cause bit, and software clears it by writing a one to that bit. A separate read-only cause bit shows the live button level. A write of zero to a third register produces a one-cycle platform reset strobe. Every asynchronous input passes through a two-flop synchroniser before use.

Top module: `intc_rsw_top`

## Requirements
- R1: After reset the mask reads 0, the sticky switch bit reads 0, irqOut is 0 and platReset is 0.
- R2: The mask register at byte offset 0x04 reads back the last value written to it. Bit n set enables source n.
- R3: For every level source (all bits except 1 and 16), cause bit n at offset 0x00 equals srcLevel[n] delayed by two clock edges. It clears by itself when the input drops.
- R4: irqOut rises on the clock edge after a cause bit and its mask bit are both 1. irqOut is low whenever the AND of cause and mask, bit 16 excluded, is zero.
- R5: A pending source whose mask bit is 0 does not assert irqOut.
- R6: A falling edge of switchRaw (1 released, 0 pressed) sets sticky cause bit 1. The bit stays set after the button is released.
- R7: Writing 1 to cause bit 1 clears the sticky bit. Writing 0 to bit 1 leaves it set. Writing 1s to level-source bits has no effect on them.
- R8: Cause bit 16 reads the synchronised switch level: 0 while pressed, 1 while released. Writes to it are ignored.
- R9: A write of 0x00000000 to offset 0x24 yields platReset high for exactly one cycle. A write of any nonzero value there yields no pulse.
- R10: After writing 0 to the mask and 0xFFFFFFFF to the cause, irqOut stays low and the sticky bit reads 0.
- R11: The srcLevel inputs at positions 1 and 16 are ignored and never appear in the cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational, 0 when not reading) |
| srcLevel | input | 32 | Asynchronous level interrupt inputs |
| switchRaw | input | 1 | Asynchronous button level, 0 = pressed |
| irqOut | output | 1 | Combined registered interrupt |
| platReset | output | 1 | One-cycle platform reset strobe |

## Verification
The level path is driven with single-bit inputs, with multi-bit patterns against partial masks, and with inputs set on the ignored positions 1 and 16. These cases separate correct masking from bit-position mixups. A single source is timed edge by edge to pin the two-stage synchroniser and the registered output. The switch is pressed, held, released and pressed again, with zero writes and one writes to the sticky bit in between. This shows that latching happens only on the press edge and that clearing needs a one in the right position. Zero and nonzero writes to the reset register show that only a zero write produces the strobe.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_RESET = 8'h24;

  typedef enum logic [1:0] {RD_NONE, RD_CAUSE, RD_MASK} rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrCause;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctlStrobe_t        strobe,
  output logic              platReset
);
  logic hitCause, hitMask, hitReset;

  assign hitCause = busAddr == OFF_CAUSE;
  assign hitMask  = busAddr == OFF_MASK;
  assign hitReset = busAddr == OFF_RESET;

  always_comb begin
    strobe.wrMask  = busSel && busWr && hitMask;
    strobe.wrCause = busSel && busWr && hitCause;
    strobe.rdSel   = RD_NONE;
    if (busSel && !busWr) begin
      if (hitCause)     strobe.rdSel = RD_CAUSE;
      else if (hitMask) strobe.rdSel = RD_MASK;
    end
  end

  // a zero write to the reset register fires a single-cycle strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) platReset <= 1'b0;
    else       platReset <= busSel && busWr && hitReset && (busWdata == '0);
  end
endmodule

// File: rtl/intc_dpath.sv
module intc_dpath
  import intc_pkg::*;
#(
  parameter int SW_IDX    = 1,
  parameter int STATE_IDX = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] srcLevel,
  input  logic              switchRaw,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] causeView,
  output logic [DATA_W-1:0] maskView,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] IRQ_ELIGIBLE = ~(DATA_W'(1) << STATE_IDX);

  logic [DATA_W-1:0] lvlS1, lvlS2, maskReg;
  logic swS1, swS2, swPrev, sticky, pressEdge, clearHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlS1 <= '0;
      lvlS2 <= '0;
      swS1 <= 1'b1;
      swS2 <= 1'b1;
      swPrev <= 1'b1;
    end else begin
      lvlS1 <= srcLevel;
      lvlS2 <= lvlS1;
      swS1 <= switchRaw;
      swS2 <= swS1;
      swPrev <= swS2;
    end
  end

  assign pressEdge = swPrev && !swS2;
  assign clearHit  = strobe.wrCause && busWdata[SW_IDX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sticky <= 1'b0;
      maskReg <= '0;
    end else begin
      sticky <= pressEdge || (sticky && !clearHit);
      if (strobe.wrMask) maskReg <= busWdata;
    end
  end

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_cause
    if (gi == SW_IDX) begin : g_sticky
      assign causeView[gi] = sticky;
    end else if (gi == STATE_IDX) begin : g_state
      assign causeView[gi] = swS2;
    end else begin : g_level
      assign causeView[gi] = lvlS2[gi];
    end
  end

  assign maskView = maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(causeView & maskReg & IRQ_ELIGIBLE);
  end

  always_comb begin
    case (strobe.rdSel)
      RD_CAUSE: busRdata = causeView;
      RD_MASK:  busRdata = maskReg;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_rsw_top.sv
module intc_rsw_top
  import intc_pkg::*;
#(
  parameter int SW_IDX    = 1,
  parameter int STATE_IDX = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] srcLevel,
  input  logic              switchRaw,
  output logic              irqOut,
  output logic              platReset
);
  ctlStrobe_t strobe;
  logic [DATA_W-1:0] causeView, maskView;

  intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .strobe(strobe), .platReset(platReset)
  );

  intc_dpath #(.SW_IDX(SW_IDX), .STATE_IDX(STATE_IDX)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .srcLevel(srcLevel), .switchRaw(switchRaw), .busRdata(busRdata),
    .causeView(causeView), .maskView(maskView), .irqOut(irqOut)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int SW_IDX    = 1,
  parameter int STATE_IDX = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] causeView,
  input logic [DATA_W-1:0] maskView,
  input logic              irqOut,
  input logic              platReset
);
  logic [DATA_W-1:0] liveMask;
  assign liveMask = causeView & maskView & ~(DATA_W'(1) << STATE_IDX);

  p_irq_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|liveMask));

  p_masked_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskView) == '0) |-> !irqOut);

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (causeView[SW_IDX] && !(busSel && busWr && busAddr == OFF_CAUSE && busWdata[SW_IDX]))
      |=> causeView[SW_IDX]);

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    platReset |=> !platReset);

  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(platReset) |-> $past(busSel && busWr && busAddr == OFF_RESET && busWdata == '0));
endmodule

bind intc_rsw_top intc_checker #(.SW_IDX(SW_IDX), .STATE_IDX(STATE_IDX)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .causeView(causeView), .maskView(maskView),
  .irqOut(irqOut), .platReset(platReset)
);

// File: tb/intc_rsw_top_test.sv
module intc_rsw_top_test;
  logic clk = 0, rstN = 0, busSel = 0, busWr = 0, switchRaw = 1;
  logic [7:0] busAddr = 0;
  logic [31:0] busWdata = 0, srcLevel = 0;
  logic [31:0] busRdata;
  logic irqOut, platReset;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intc_rsw_top uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0; busWdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h04, d); check("R1 mask", d, 0);
    rd(8'h00, d); check("R1 sticky", d[1], 0);
    check("R1 irq", irqOut, 0);
    check("R1 preset", platReset, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h04, 32'hA5C3_0F81); rd(8'h04, d); check("R2 mask rw", d, 32'hA5C3_0F81);
    wr(8'h04, 0); rd(8'h04, d); check("R2 mask zero", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h04, 32'h0000_0008);
    srcLevel = 32'h0000_0008;
    cyc(1); rd(8'h00, d); check("R3 one edge", d[3], 0);
    cyc(1); rd(8'h00, d); check("R3 two edges", d[3], 1);
    check("R4 before", irqOut, 0);
    cyc(1); check("R4 after", irqOut, 1);
    srcLevel = 0; cyc(3);
    rd(8'h00, d); check("R3 self clear", d[3], 0);
    check("R4 drop", irqOut, 0);
    srcLevel = 32'h8000_0020; cyc(3);
    rd(8'h00, d); check("R3 multi", d & 32'hFFFE_FFFD, 32'h8000_0020);
    check("R5 masked", irqOut, 0);
    wr(8'h04, 32'h8000_0000); cyc(2); check("R4 partial mask", irqOut, 1);
    wr(8'h00, 32'hFFFE_FFFD); rd(8'h00, d); check("R7 level w1 noeffect", d & 32'hFFFE_FFFD, 32'h8000_0020);
    srcLevel = 32'h0001_0002; wr(8'h04, 32'hFFFF_FFFF); cyc(4);
    rd(8'h00, d); check("R11 ignored", d, 32'h0001_0000);
    check("R11 irq", irqOut, 0);
    srcLevel = 0; wr(8'h04, 0); cyc(3);
  endtask

  task automatic t_switch();
    logic [31:0] d;
    rd(8'h00, d); check("R8 released", d[16], 1);
    switchRaw = 0; cyc(4);
    rd(8'h00, d); check("R8 pressed", d[16], 0); check("R6 latch", d[1], 1);
    switchRaw = 1; cyc(4);
    rd(8'h00, d); check("R6 sticky", d[1], 1); check("R8 back", d[16], 1);
    wr(8'h00, 32'h0001_0000); rd(8'h00, d); check("R8 write ign", d[16], 1);
    wr(8'h04, 32'h0000_0002); cyc(1); check("R4 sw irq", irqOut, 1);
    wr(8'h00, 0); rd(8'h00, d); check("R7 zero write", d[1], 1);
    wr(8'h00, 32'h0000_0002); rd(8'h00, d); check("R7 w1c", d[1], 0);
    cyc(1); check("R7 irq gone", irqOut, 0);
    switchRaw = 0; cyc(4); switchRaw = 1; cyc(4);
    rd(8'h00, d); check("R6 second press", d[1], 1);
  endtask

  task automatic t_quiesce();
    logic [31:0] d;
    srcLevel = 32'h0F0F_0F0C; wr(8'h04, 32'hFFFF_FFFF); cyc(3);
    check("R10 pre", irqOut, 1);
    wr(8'h04, 0); wr(8'h00, 32'hFFFF_FFFF); cyc(2);
    check("R10 irq", irqOut, 0);
    rd(8'h00, d); check("R10 sticky", d[1], 0);
    srcLevel = 0; cyc(3);
  endtask

  task automatic t_preset();
    wr(8'h24, 32'h0000_0001); cyc(1);
    check("R9 nonzero", platReset, 0);
    busSel = 1; busWr = 1; busAddr = 8'h24; busWdata = 0;
    @(negedge clk); busSel = 0; busWr = 0;
    check("R9 pulse", platReset, 1);
    cyc(1); check("R9 single", platReset, 0);
  endtask

  initial begin
    cyc(3); rstN = 1; cyc(1);
    t_reset(); t_mask(); t_level(); t_switch(); t_quiesce(); t_preset();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule